// File: doc/BRIEF.md
# Bit-Oriented Message Receiver

This block sits on the data-link channel recovered from the framing-bit positions of an extended-superframe T1 stream. Each data-link bit arrives with a one-cycle valid strobe. The block runs a 16-bit sliding window over those bits and looks for a framed message. A framed message is a run of eight ones, a zero, six code bits and a closing zero. The six code bits are the message.

A single reception is not trusted. Each matched code goes into a short history. A code is accepted once it has appeared in 4 of the last 5 matched frames. When the window-select input is high, 8 of the last 10 are needed instead. An accepted code is declared only if it differs from the code declared before it. A declaration loads the code output register and sets a sticky indication flag. Software clears that flag by writing one to it. The interrupt output follows the flag, masked by an enable.

Top module: `bom_rx_top`

## Requirements
- R1: A frame is recognised when the 16 most recent valid bits are, oldest first, eight ones, a zero, six code bits and a zero. The first-received code bit becomes code_o[5] and the last becomes code_o[0].
- R2: Cycles with dl_valid_i low do not shift the window and do not count as frame bits, whatever dl_bit_i holds.
- R3: With win_sel_i low, a code is qualified when it appears in at least 4 of the 5 most recent matched frames, counting the current frame.
- R4: With win_sel_i high, a code is qualified when it appears in at least 8 of the 10 most recent matched frames, counting the current frame.
- R5: A qualified code equal to the currently declared code is not declared again: code_o holds and ind_o is not set.
- R6: The first qualified code after reset is always declared, whatever its value.
- R7: A declaration loads code_o on the clock edge after the edge that captured the frame's last bit, and sets ind_o on that same edge.
- R8: A one on ind_clr_i clears ind_o on the next edge. If a declaration happens on that same edge, ind_o stays set.
- R9: irq_o is registered. After each edge it equals the new ind_o value ANDed with irq_en_i as sampled on that edge.
- R10: While rst_i is high on a clock edge, code_o, ind_o and irq_o become 0, and the match history is emptied.
- R11: A 16-bit block whose closing bit is 1 is not a frame and does not enter the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| dl_bit_i | input | 1 | Data-link bit |
| dl_valid_i | input | 1 | Qualifies dl_bit_i for one cycle |
| win_sel_i | input | 1 | 0: 4-of-5 window, 1: 8-of-10 window |
| irq_en_i | input | 1 | Interrupt enable |
| ind_clr_i | input | 1 | Write-one-to-clear strobe for the indication flag |
| code_o | output | 6 | Last declared message code |
| ind_o | output | 1 | Sticky indication flag, set on each code update |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench checks where the qualification threshold lies. Three matches out of five must not declare a code, and the fourth must. A design that counted the wrong window or left out the current frame would declare one frame early or one frame late. Noise frames are interleaved, and a 4-match run in long-window mode must not declare. A design that ignored win_sel_i would declare there. The bench also sends a repeat of the declared code. It sends a corrupted frame with idle, invalid junk bits around it. It pulses the clear strobe on the exact edge of a declaration, where a design with the wrong priority would drop the flag. It toggles the enable to expose an unmasked or combinational interrupt.

// File: rtl/bom_rx_pkg.sv
package bom_rx_pkg;
  parameter int unsigned CODE_W    = 6;
  parameter int unsigned FLAG_ONES = 8;
  localparam int unsigned FRAME_W  = FLAG_ONES + CODE_W + 2;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/bom_frame_det.sv
module bom_frame_det
  import bom_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  bit_i,
  input  logic  valid_i,
  output logic  hit_o,
  output code_t code_o
);
  logic [FRAME_W-1:0] win_q;
  logic               fresh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      win_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= valid_i;
      if (valid_i) win_q <= {win_q[FRAME_W-2:0], bit_i};
    end
  end

  logic flag_ok;
  assign flag_ok = &win_q[FRAME_W-1 -: FLAG_ONES];
  assign hit_o   = fresh_q && flag_ok && !win_q[CODE_W+1] && !win_q[0];
  assign code_o  = win_q[CODE_W:1];

  // R2: window moves only on valid bits
  a_r2_window_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_i |=> win_q == $past(win_q));
  // R11: a hit never has a one in its closing bit
  a_r11_close_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> !win_q[0]);
endmodule

// File: rtl/bom_qualifier.sv
module bom_qualifier
  import bom_rx_pkg::*;
#(
  parameter int unsigned HIST_D     = 10,
  parameter int unsigned SHORT_WIN  = 5,
  parameter int unsigned SHORT_NEED = 4,
  parameter int unsigned LONG_WIN   = 10,
  parameter int unsigned LONG_NEED  = 8
) (
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  hit_i,
  input  code_t code_i,
  input  logic  win_sel_i,
  output logic  qual_o
);
  localparam int unsigned CNT_W = $clog2(HIST_D + 2);

  code_t            hist_q [HIST_D];
  logic [HIST_D-1:0] hv_q;
  logic [HIST_D-1:0] eq;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hv_q <= '0;
      for (int i = 0; i < HIST_D; i++) hist_q[i] <= '0;
    end else if (hit_i) begin
      hv_q      <= {hv_q[HIST_D-2:0], 1'b1};
      hist_q[0] <= code_i;
      for (int i = 1; i < HIST_D; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  for (genvar g = 0; g < HIST_D; g++) begin : g_cmp
    assign eq[g] = hv_q[g] && (hist_q[g] == code_i);
  end

  int unsigned win_len;
  int unsigned need;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    win_len = win_sel_i ? LONG_WIN : SHORT_WIN;
    need    = win_sel_i ? LONG_NEED : SHORT_NEED;
    cnt     = CNT_W'(1);
    for (int i = 0; i < HIST_D; i++) begin
      if ((i + 1 < win_len) && eq[i]) cnt = cnt + CNT_W'(1);
    end
  end

  assign qual_o = hit_i && (cnt >= CNT_W'(need));

  // R3/R4: qualification only ever arises from a matched frame
  a_r3_qual_needs_hit: assert property (@(posedge clk_i) disable iff (rst_i)
    qual_o |-> hit_i);
  // R10: history is empty in the cycle after reset
  a_r10_hist_empty: assert property (@(posedge clk_i)
    $past(rst_i) |-> hv_q == '0);
endmodule

// File: rtl/bom_flag_unit.sv
module bom_flag_unit (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic ind_o,
  output logic irq_o
);
  logic ind_q, irq_q, ind_nx;

  assign ind_nx = set_i | (ind_q & ~clr_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ind_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ind_q <= ind_nx;
      irq_q <= ind_nx & en_i;
    end
  end

  assign ind_o = ind_q;
  assign irq_o = irq_q;

  // R8: a set wins over a simultaneous clear
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    set_i |=> ind_q);
  // R8: clear without set empties the flag
  a_r8_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !set_i) |=> !ind_q);
  // R9: interrupt only with the flag set
  a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_q |-> ind_q);
  a_r9_irq_masked: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> !irq_q);
endmodule

// File: rtl/bom_rx_top.sv
module bom_rx_top
  import bom_rx_pkg::*;
#(
  parameter int unsigned HIST_D     = 10,
  parameter int unsigned SHORT_WIN  = 5,
  parameter int unsigned SHORT_NEED = 4,
  parameter int unsigned LONG_WIN   = 10,
  parameter int unsigned LONG_NEED  = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              dl_bit_i,
  input  logic              dl_valid_i,
  input  logic              win_sel_i,
  input  logic              irq_en_i,
  input  logic              ind_clr_i,
  output logic [CODE_W-1:0] code_o,
  output logic              ind_o,
  output logic              irq_o
);
  logic  hit, qual, decl;
  code_t hit_code, code_q;
  logic  prev_vld_q;

  bom_frame_det u_det (
    .clk_i(clk_i), .rst_i(rst_i), .bit_i(dl_bit_i), .valid_i(dl_valid_i),
    .hit_o(hit), .code_o(hit_code)
  );

  bom_qualifier #(
    .HIST_D(HIST_D), .SHORT_WIN(SHORT_WIN), .SHORT_NEED(SHORT_NEED),
    .LONG_WIN(LONG_WIN), .LONG_NEED(LONG_NEED)
  ) u_qual (
    .clk_i(clk_i), .rst_i(rst_i), .hit_i(hit), .code_i(hit_code),
    .win_sel_i(win_sel_i), .qual_o(qual)
  );

  assign decl = qual && (!prev_vld_q || (hit_code != code_q));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      code_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (decl) begin
      code_q     <= hit_code;
      prev_vld_q <= 1'b1;
    end
  end

  bom_flag_unit u_flag (
    .clk_i(clk_i), .rst_i(rst_i), .set_i(decl), .clr_i(ind_clr_i),
    .en_i(irq_en_i), .ind_o(ind_o), .irq_o(irq_o)
  );

  assign code_o = code_q;

  // R5: a repeat of the declared code leaves the register unchanged
  a_r5_no_repeat: assert property (@(posedge clk_i) disable iff (rst_i)
    (qual && prev_vld_q && hit_code == code_q) |=> code_q == $past(code_q));
  // R6: the first qualified code after reset is declared
  a_r6_first: assert property (@(posedge clk_i) disable iff (rst_i)
    (qual && !prev_vld_q) |=> prev_vld_q);
  // R7: any change of the code register comes with the flag set
  a_r7_update_flags: assert property (@(posedge clk_i) disable iff (rst_i)
    (code_q != $past(code_q)) |-> ind_o);
endmodule

// File: tb/bom_rx_tb.sv
module bom_rx_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, dl_bit, dl_valid, win_sel, irq_en, ind_clr;
  logic [5:0] code;
  logic       ind, irq;
  int         total = 0;
  int         bad = 0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bom_rx_top dut_i (
    .clk_i(clk), .rst_i(rst), .dl_bit_i(dl_bit), .dl_valid_i(dl_valid),
    .win_sel_i(win_sel), .irq_en_i(irq_en), .ind_clr_i(ind_clr),
    .code_o(code), .ind_o(ind), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // send one 16-bit frame; closing bit forced to 1 when corrupt is set
  task automatic send_frame(input logic [5:0] c, input logic corrupt, input logic junk);
    logic [15:0] f;
    f = {8'hFF, 1'b0, c, corrupt};
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      dl_bit = f[i];
      dl_valid = 1'b1;
      if (junk) begin
        @(negedge clk);
        dl_valid = 1'b0;
        dl_bit = ~f[i];
      end
    end
    @(negedge clk);
    dl_valid = 1'b0;
    dl_bit = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); ind_clr = 1'b1;
    @(negedge clk); ind_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 code after reset", {2'b0, code}, 8'h00);
    chk("R10 ind after reset", {7'b0, ind}, 8'h00);
    chk("R10 irq after reset", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_first_short();
    for (int k = 0; k < 3; k++) send_frame(6'h2A, 1'b0, 1'b0);
    settle();
    chk("R3 three of five not enough", {7'b0, ind}, 8'h00);
    send_frame(6'h2A, 1'b0, 1'b0);
    settle();
    chk("R6 first code declared", {2'b0, code}, 8'h2A);
    chk("R7 flag set on update", {7'b0, ind}, 8'h01);
  endtask

  task automatic t_repeat();
    clear_flag();
    chk("R8 clear flag", {7'b0, ind}, 8'h00);
    for (int k = 0; k < 5; k++) send_frame(6'h2A, 1'b0, 1'b0);
    settle();
    chk("R5 repeat not declared ind", {7'b0, ind}, 8'h00);
    chk("R5 repeat code holds", {2'b0, code}, 8'h2A);
  endtask

  task automatic t_interleave();
    send_frame(6'h15, 1'b0, 1'b0);
    send_frame(6'h33, 1'b0, 1'b0);
    send_frame(6'h15, 1'b0, 1'b0);
    send_frame(6'h15, 1'b0, 1'b0);
    settle();
    chk("R3 noise frame breaks count", {7'b0, ind}, 8'h00);
    send_frame(6'h15, 1'b0, 1'b0);
    settle();
    chk("R1 R3 code order", {2'b0, code}, 8'h15);
    chk("R7 flag on new code", {7'b0, ind}, 8'h01);
    clear_flag();
  endtask

  task automatic t_long();
    win_sel = 1'b1;
    for (int k = 0; k < 4; k++) send_frame(6'h0F, 1'b0, 1'b0);
    settle();
    chk("R4 four not enough in long mode", {7'b0, ind}, 8'h00);
    for (int k = 0; k < 3; k++) send_frame(6'h0F, 1'b0, 1'b0);
    settle();
    chk("R4 seven not enough", {2'b0, code}, 8'h15);
    send_frame(6'h0F, 1'b0, 1'b0);
    settle();
    chk("R4 eight of ten declares", {2'b0, code}, 8'h0F);
    clear_flag();
    win_sel = 1'b0;
  endtask

  task automatic t_corrupt();
    for (int k = 0; k < 3; k++) send_frame(6'h01, 1'b0, 1'b1);
    send_frame(6'h01, 1'b1, 1'b1);
    settle();
    chk("R11 corrupt frame not counted", {7'b0, ind}, 8'h00);
    chk("R2 junk bits ignored", {2'b0, code}, 8'h0F);
    send_frame(6'h01, 1'b0, 1'b1);
    settle();
    chk("R2 gapped frames declare", {2'b0, code}, 8'h01);
    clear_flag();
  endtask

  task automatic t_clear_race();
    for (int k = 0; k < 3; k++) send_frame(6'h3E, 1'b0, 1'b0);
    send_frame(6'h3E, 1'b0, 1'b0);
    ind_clr = 1'b1;
    @(negedge clk);
    ind_clr = 1'b0;
    chk("R8 set wins over clear", {7'b0, ind}, 8'h01);
    chk("R7 update edge", {2'b0, code}, 8'h3E);
  endtask

  task automatic t_irq();
    irq_en = 1'b0;
    settle();
    chk("R9 irq masked", {7'b0, irq}, 8'h00);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R9 irq follows enable", {7'b0, irq}, 8'h01);
    clear_flag();
    chk("R9 irq drops with flag", {7'b0, irq}, 8'h00);
    irq_en = 1'b0;
  endtask

  initial begin
    rst = 1'b1; dl_bit = 1'b0; dl_valid = 1'b0;
    win_sel = 1'b0; irq_en = 1'b0; ind_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_short();
    t_repeat();
    t_interleave();
    t_long();
    t_corrupt();
    t_clear_race();
    t_irq();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule